// File: doc/BRIEF.md
# Adaptive Branch Forwarding Controller

This block sets how many retired branch outcomes a leading core passes to a trailing redundant core, and it tunes that amount while the program runs. The trailing side keeps a signed, saturating score of dispatch stalls. Stalls caused by an unresolved branch raise the score. Stalls for any other reason lower it. At each synchronization pulse the score is compared with a programmable threshold. The result is a one-cycle request to raise or lower the forwarding level, and the score then returns to zero.

The leading side holds the level in a five-state machine: `LVL_1`, `LVL_2`, `LVL_3`, `LVL_4` and `LVL_5`. An up request moves the machine to the next higher state (`LVL_1`→`LVL_2`→`LVL_3`→`LVL_4`→`LVL_5`). A down request moves it to the next lower state. `LVL_5` stays put on an up request, `LVL_1` stays put on a down request, and every state holds when no request arrives.

Each state selects a stride over a free-running count of accepted retired branches:
- `LVL_1` forwards nothing on stride.
- `LVL_2`, `LVL_3` and `LVL_4` forward when the count modulo 8, 4 or 2 is zero.
- `LVL_5` forwards every branch.

A mispredicted branch is forwarded at every level. A forwarded outcome leaves on a valid/ready port carrying its tag, taken bit and target. Retirement is held back while that port is not ready.

Top module: `branch_assist_ctrl`

## Requirements
- R1: During and after reset the level output is 1, no request is pending, the stall score is zero and the branch count is zero.
- R2: The stall score rises by one in a cycle where the branch-stall input is high, and falls by one in a cycle where only the other-stall input is high. If both inputs are high, the branch stall wins. The score saturates at +127 and at -128.
- R3: A synchronization pulse produces, in the next cycle, `req_valid_o`=1 with `req_up_o`=1 if the signed score before that pulse is strictly greater than `threshold_i`, and `req_up_o`=0 otherwise. The score is cleared to zero in the same cycle, and the stall inputs of that cycle are not counted.
- R4: A request moves the level by exactly one step, visible on `level_o` one cycle after `req_valid_o`. The level stays within 1..5: an up request at 5 and a down request at 1 leave it unchanged. Without a request the level holds.
- R5: A retired branch with the mispredict bit set is always offered on the forward port, whatever the level.
- R6: A branch without a mispredict is selected as follows, where c is the branch count:
  - level 1: never;
  - level 2: when c mod 8 = 0;
  - level 3: when c mod 4 = 0;
  - level 4: when c mod 2 = 0;
  - level 5: always.
- R7: The branch count is a 3-bit counter. It advances by one, wrapping, for each accepted retired branch, whether forwarded or not. It is not reset by level changes.
- R8: `fwd_valid_o` equals `ret_valid_i` AND selected. `ret_ready_o` is low exactly when the branch is selected and `fwd_ready_i` is low. `fwd_tag_o`, `fwd_taken_o` and `fwd_target_o` carry the retired branch's fields in the same cycle.
- R9: `level_o` gives the level as the unsigned values 1 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_br_i | input | 1 | Trailing dispatch stalled on an unresolved branch this cycle |
| stall_other_i | input | 1 | Trailing dispatch stalled for another reason this cycle |
| sync_i | input | 1 | Synchronization pulse between the cores |
| threshold_i | input | 8 | Signed threshold compared with the stall score |
| req_valid_o | output | 1 | Level change request issued this cycle |
| req_up_o | output | 1 | Request direction: 1 raises, 0 lowers |
| level_o | output | 3 | Current forwarding level, 1 to 5 |
| ret_valid_i | input | 1 | A retired branch is offered |
| ret_mispred_i | input | 1 | The retired branch was mispredicted |
| ret_taken_i | input | 1 | Branch taken bit |
| ret_tag_i | input | 8 | Instruction tag of the branch |
| ret_target_i | input | 32 | Branch target |
| ret_ready_o | output | 1 | Retirement may proceed this cycle |
| fwd_valid_o | output | 1 | A branch outcome is offered to the trailing core |
| fwd_ready_i | input | 1 | The trailing side accepts the outcome |
| fwd_tag_o | output | 8 | Forwarded tag |
| fwd_taken_o | output | 1 | Forwarded taken bit |
| fwd_target_o | output | 32 | Forwarded target |

## Verification
The forward port results (`fwd_valid_o`, `ret_ready_o` and the payload) are combinational. They are due in the same cycle as the retired branch, and the bench checks them one time step after it drives its inputs at the falling edge. A request is due one cycle after the synchronization pulse, and the new level one cycle after that. The bench compares these with its model at the next falling edge, after the model has applied the same clock edge. Directed phases drive the score into both saturation limits and the level into both ends. A seeded random phase mixes stall reasons, mispredicts, back-pressure and synchronization pulses.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    typedef enum logic [2:0] {
        LVL_1 = 3'd1,
        LVL_2 = 3'd2,
        LVL_3 = 3'd3,
        LVL_4 = 3'd4,
        LVL_5 = 3'd5
    } level_e;

    localparam int LEVEL_W = 3;
    localparam int BCNT_W  = 3;   // stride up to 8 needs three count bits

endpackage

// File: rtl/bfc_stall_monitor.sv
module bfc_stall_monitor #(
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stall_br_i,
    input  logic                 stall_other_i,
    input  logic                 sync_i,
    input  logic signed [CW-1:0] threshold_i,
    output logic                 req_valid_o,
    output logic                 req_up_o
);

    localparam logic signed [CW-1:0] SCORE_MAX = {1'b0, {(CW-1){1'b1}}};
    localparam logic signed [CW-1:0] SCORE_MIN = {1'b1, {(CW-1){1'b0}}};

    logic signed [CW-1:0] score_q;
    logic signed [CW-1:0] score_d;

    always_comb begin
        score_d = score_q;
        if (sync_i) begin
            score_d = '0;
        end else if (stall_br_i) begin
            if (score_q != SCORE_MAX) score_d = score_q + 1'b1;
        end else if (stall_other_i) begin
            if (score_q != SCORE_MIN) score_d = score_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            score_q     <= '0;
            req_valid_o <= 1'b0;
            req_up_o    <= 1'b0;
        end else begin
            score_q     <= score_d;
            req_valid_o <= sync_i;
            req_up_o    <= sync_i && (score_q > threshold_i);
        end
    end

    AST_SCORE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (score_q == '0)); // R3
    AST_REQ_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> req_valid_o); // R3
    AST_NO_SPURIOUS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i |=> !req_valid_o); // R3
    AST_SCORE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && stall_br_i && score_q == SCORE_MAX) |=> (score_q == SCORE_MAX)); // R2
    AST_SCORE_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && !stall_br_i && stall_other_i && score_q == SCORE_MIN) |=> (score_q == SCORE_MIN)); // R2

endmodule

// File: rtl/bfc_level_fsm.sv
module bfc_level_fsm
    import bfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_up_i,
    output logic [LEVEL_W-1:0] level_o,
    output logic              stride_en_o,
    output logic [BCNT_W-1:0] stride_mask_o
);

    level_e state_q;
    level_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_1: if (req_valid_i && req_up_i)  state_d = LVL_2;
            LVL_2: if (req_valid_i)              state_d = req_up_i ? LVL_3 : LVL_1;
            LVL_3: if (req_valid_i)              state_d = req_up_i ? LVL_4 : LVL_2;
            LVL_4: if (req_valid_i)              state_d = req_up_i ? LVL_5 : LVL_3;
            LVL_5: if (req_valid_i && !req_up_i) state_d = LVL_4;
            default:                             state_d = LVL_1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_1;
        else        state_q <= state_d;
    end

    always_comb begin
        stride_en_o   = 1'b1;
        stride_mask_o = '0;
        unique case (state_q)
            LVL_1: begin stride_en_o = 1'b0; stride_mask_o = '1; end
            LVL_2: stride_mask_o = BCNT_W'(7);
            LVL_3: stride_mask_o = BCNT_W'(3);
            LVL_4: stride_mask_o = BCNT_W'(1);
            LVL_5: stride_mask_o = '0;
            default: begin stride_en_o = 1'b0; stride_mask_o = '1; end
        endcase
    end

    assign level_o = state_q;

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o >= 3'd1) && (level_o <= 3'd5)); // R4
    AST_LEVEL_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_up_i && level_o != 3'd5) |=> (level_o == $past(level_o) + 3'd1)); // R4
    AST_LEVEL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_up_i && level_o != 3'd1) |=> (level_o == $past(level_o) - 3'd1)); // R4
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> $stable(level_o)); // R4

endmodule

// File: rtl/bfc_fwd_select.sv
module bfc_fwd_select
    import bfc_pkg::*;
#(
    parameter int TAG_W  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stride_en_i,
    input  logic [BCNT_W-1:0] stride_mask_i,
    input  logic              ret_valid_i,
    input  logic              ret_mispred_i,
    input  logic              ret_taken_i,
    input  logic [TAG_W-1:0]  ret_tag_i,
    input  logic [ADDR_W-1:0] ret_target_i,
    output logic              ret_ready_o,
    output logic              fwd_valid_o,
    input  logic              fwd_ready_i,
    output logic [TAG_W-1:0]  fwd_tag_o,
    output logic              fwd_taken_o,
    output logic [ADDR_W-1:0] fwd_target_o
);

    logic [BCNT_W-1:0] bcnt_q;
    logic              stride_hit;
    logic              selected;
    logic              accept;

    assign stride_hit   = stride_en_i && ((bcnt_q & stride_mask_i) == '0);
    assign selected     = ret_mispred_i || stride_hit;
    assign fwd_valid_o  = ret_valid_i && selected;
    assign ret_ready_o  = !selected || fwd_ready_i;
    assign accept       = ret_valid_i && ret_ready_o;
    assign fwd_tag_o    = ret_tag_i;
    assign fwd_taken_o  = ret_taken_i;
    assign fwd_target_o = ret_target_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bcnt_q <= '0;
        else if (accept) bcnt_q <= bcnt_q + 1'b1;
    end

    AST_MISPRED_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && ret_mispred_i) |-> fwd_valid_o); // R5
    AST_RETIRE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && !ret_ready_o) |-> (fwd_valid_o && !fwd_ready_i)); // R8
    AST_BCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && ret_ready_o) |=> (bcnt_q == $past(bcnt_q) + 1'b1)); // R7
    AST_BCNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_valid_i && ret_ready_o) |=> $stable(bcnt_q)); // R7

endmodule

// File: rtl/branch_assist_ctrl.sv
module branch_assist_ctrl
    import bfc_pkg::*;
#(
    parameter int CW     = 8,
    parameter int TAG_W  = 8,
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stall_br_i,
    input  logic                 stall_other_i,
    input  logic                 sync_i,
    input  logic signed [CW-1:0] threshold_i,
    output logic                 req_valid_o,
    output logic                 req_up_o,
    output logic [2:0]           level_o,
    input  logic                 ret_valid_i,
    input  logic                 ret_mispred_i,
    input  logic                 ret_taken_i,
    input  logic [TAG_W-1:0]     ret_tag_i,
    input  logic [ADDR_W-1:0]    ret_target_i,
    output logic                 ret_ready_o,
    output logic                 fwd_valid_o,
    input  logic                 fwd_ready_i,
    output logic [TAG_W-1:0]     fwd_tag_o,
    output logic                 fwd_taken_o,
    output logic [ADDR_W-1:0]    fwd_target_o
);

    logic              stride_en;
    logic [BCNT_W-1:0] stride_mask;

    bfc_stall_monitor #(.CW(CW)) u_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall_br_i   (stall_br_i),
        .stall_other_i(stall_other_i),
        .sync_i       (sync_i),
        .threshold_i  (threshold_i),
        .req_valid_o  (req_valid_o),
        .req_up_o     (req_up_o)
    );

    bfc_level_fsm u_level (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_o),
        .req_up_i     (req_up_o),
        .level_o      (level_o),
        .stride_en_o  (stride_en),
        .stride_mask_o(stride_mask)
    );

    bfc_fwd_select #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_select (
        .clk          (clk),
        .rst_n        (rst_n),
        .stride_en_i  (stride_en),
        .stride_mask_i(stride_mask),
        .ret_valid_i  (ret_valid_i),
        .ret_mispred_i(ret_mispred_i),
        .ret_taken_i  (ret_taken_i),
        .ret_tag_i    (ret_tag_i),
        .ret_target_i (ret_target_i),
        .ret_ready_o  (ret_ready_o),
        .fwd_valid_o  (fwd_valid_o),
        .fwd_ready_i  (fwd_ready_i),
        .fwd_tag_o    (fwd_tag_o),
        .fwd_taken_o  (fwd_taken_o),
        .fwd_target_o (fwd_target_o)
    );

endmodule

// File: tb/branch_assist_ctrl_test.sv
`timescale 1ns/1ps
module branch_assist_ctrl_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              stall_br = 1'b0, stall_other = 1'b0, sync = 1'b0;
    logic signed [7:0] thr = 8'sd0;
    logic              req_valid, req_up;
    logic [2:0]        level;
    logic              ret_valid = 1'b0, ret_mispred = 1'b0, ret_taken = 1'b0;
    logic [7:0]        ret_tag = '0;
    logic [31:0]       ret_target = '0;
    logic              ret_ready, fwd_valid;
    logic              fwd_ready = 1'b1;
    logic [7:0]        fwd_tag;
    logic              fwd_taken;
    logic [31:0]       fwd_target;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    // model state
    int m_score = 0;
    bit m_rv = 0, m_up = 0;
    int m_level = 1;
    int m_bcnt = 0;

    always #4 clk = ~clk;

    branch_assist_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .stall_br_i(stall_br), .stall_other_i(stall_other), .sync_i(sync),
        .threshold_i(thr), .req_valid_o(req_valid), .req_up_o(req_up), .level_o(level),
        .ret_valid_i(ret_valid), .ret_mispred_i(ret_mispred), .ret_taken_i(ret_taken),
        .ret_tag_i(ret_tag), .ret_target_i(ret_target), .ret_ready_o(ret_ready),
        .fwd_valid_o(fwd_valid), .fwd_ready_i(fwd_ready), .fwd_tag_o(fwd_tag),
        .fwd_taken_o(fwd_taken), .fwd_target_o(fwd_target)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    function automatic bit sel_f(int lvl, int c, bit mis);
        if (mis) return 1;                   // R5
        case (lvl)                           // R6
            1: return 0;
            2: return (c % 8) == 0;
            3: return (c % 4) == 0;
            4: return (c % 2) == 0;
            default: return 1;
        endcase
    endfunction

    // one cycle: check registered outputs, apply inputs, check comb outputs, advance model
    task automatic step(input bit sb, input bit so, input bit sy, input int th,
                        input bit rv, input bit mis, input bit fr);
        bit sel, rdy;
        @(negedge clk);
        cycles++;
        check("R3", "req_valid_o", req_valid, m_rv);
        if (m_rv) check("R3", "req_up_o", req_up, m_up);
        check("R4", "level_o", level, m_level);
        stall_br = sb; stall_other = so; sync = sy; thr = 8'(th);
        ret_valid = rv; ret_mispred = mis; fwd_ready = fr;
        ret_taken = 1'($urandom); ret_tag = 8'($urandom); ret_target = $urandom;
        #1;
        sel = sel_f(m_level, m_bcnt, mis);
        rdy = !sel || fr;
        check("R6", "fwd_valid_o", fwd_valid, rv && sel);
        check("R8", "ret_ready_o", ret_ready, rdy);
        if (fwd_valid && rv) begin
            check("R8", "fwd_tag_o", fwd_tag, ret_tag);
            check("R8", "fwd_taken_o", fwd_taken, ret_taken);
            check("R8", "fwd_target_o", fwd_target, ret_target);
        end
        // model update for the coming edge
        if (m_rv) begin
            if (m_up && m_level < 5) m_level++;
            else if (!m_up && m_level > 1) m_level--;
        end
        m_rv = sy;
        m_up = sy && (m_score > th);
        if (sy) m_score = 0;
        else if (sb) begin if (m_score < 127) m_score++; end
        else if (so) begin if (m_score > -128) m_score--; end
        if (rv && rdy) m_bcnt = (m_bcnt + 1) % 8;  // R7
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "level_o in reset", level, 1);
        check("R1", "req_valid_o in reset", req_valid, 0);
        check("R9", "level encoding", level, 3'd1);
        @(negedge clk) rst_n = 1'b1;

        // R2/R4: raise level up to the top and beyond
        for (int k = 0; k < 6; k++) begin
            step(1, 0, 0, 0, 1, 0, 1);
            step(0, 0, 1, 0, 1, 0, 1);
        end
        step(0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 1);
        check("R4", "saturate at 5", level, 5);
        // R6 level 5 forwards everything, with back-pressure (R8)
        for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 1, 0, k % 2);

        // R2 positive saturation: 200 branch stalls, threshold 126 -> up
        for (int k = 0; k < 200; k++) step(1, 1, 0, 0, 0, 0, 1);
        step(0, 0, 1, 126, 0, 0, 1);
        // again with threshold 127 -> down (127 is not above 127)
        for (int k = 0; k < 200; k++) step(1, 0, 0, 0, 0, 0, 1);
        step(0, 0, 1, 127, 0, 0, 1);
        // R2 negative saturation, threshold -128 -> down
        for (int k = 0; k < 200; k++) step(0, 1, 0, 0, 0, 0, 1);
        step(0, 0, 1, -128, 0, 0, 1);
        // drive to level 1 and past it
        for (int k = 0; k < 6; k++) step(0, 0, 1, 0, 1, 0, 1);
        step(0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 1);
        check("R4", "saturate at 1", level, 1);
        // level 1: only mispredicts forwarded (R5, R6)
        for (int k = 0; k < 10; k++) step(0, 0, 0, 0, 1, k % 3 == 0, 0);

        // constrained random phase
        for (int k = 0; k < 4000; k++) begin
            int r = int'($urandom_range(0, 3));
            step(r == 0, r == 1 || r == 0, $urandom_range(0, 15) == 0,
                 int'($urandom_range(0, 40)) - 20,
                 $urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0,
                 $urandom_range(0, 3) != 0);
        end
        step(0, 0, 0, 0, 0, 0, 1);
        finish_run();
    end

endmodule